// File: doc/BRIEF.md
# SPI Serial SRAM Slave Front End

This block is the serial side of a byte-wide 128K-entry memory. A host talks to it over a four-wire serial bus with an extra pause pin. Each select period carries one command byte, a 24-bit address of which only the low 17 bits matter, and then any number of data bytes. Read data is streamed out and write data is committed to a synchronous memory port. The address advances by one after every byte, for as long as select stays low.

All serial pins are brought into the system clock domain through synchronizer chains, and every serial event is handled there as a one-cycle pulse. The bus mode is taken from the serial clock level at the moment select falls: low means mode 0 and high means mode 3. In both modes, input bits are taken on the rising serial clock edge and output bits change on the falling edge, most significant bit first. The memory port uses registered read data. A read issued in one cycle returns its byte in the next cycle. Read bytes are fetched one byte ahead of the host.

Top module: `spi_sram_front`

## Requirements
- R1: While reset is high and after it is released, `spi_miso_oe`, `mem_we` and `mem_re` are low until a command asks for them.
- R2: Command byte 0x02, then three address bytes sent most significant byte first, then a data byte, writes that byte at the low 17 bits of the address. The upper 7 address bits are ignored.
- R3: Command byte 0x03, then three address bytes, streams the stored bytes out on `spi_miso`. Each bit changes after a falling serial clock edge and is valid at the next rising edge, MSB first, and `spi_miso_oe` stays high during the data phase.
- R4: While select stays low, each further data byte uses the next address, both when writing and when reading.
- R5: The burst address wraps from 0x1FFFF to 0x00000.
- R6: The serial clock level at the select falling edge picks the mode: low for mode 0, high for mode 3. Writes and reads work in both modes, and a byte written in one mode reads back in the other.
- R7: While select is high, serial clock and data activity has no effect: no memory access takes place and `spi_miso_oe` stays low.
- R8: With select low and the pause pin low, serial clock edges are ignored and `spi_miso_oe` is low. When the pause pin returns high, the transfer continues with no loss of bits.
- R9: A command byte other than 0x02 or 0x03 causes every following byte to be ignored until select goes high. Only the first byte of a select period is decoded as a command.
- R10: A write data byte is committed only after all 8 of its bits have arrived. A partial byte cut off by select rising is dropped.
- R11: `mem_we` and `mem_re` are single-cycle pulses, never high together, and each write pulse carries one complete byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; low means the pad floats |
| mem_addr | output | 17 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is due on `mem_rdata` the next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench builds the block with its defaults: 17 address bits, three address bytes, byte-wide data and two synchronizer stages. With 17 address bits, a four-byte burst that starts two bytes below the top reaches the wrap point. With three address bytes, an address whose top byte is nonzero exercises the discard of the upper bits. Two synchronizer stages keep the worst-case event delay well inside a serial half period of ten system clocks, which leaves room for the one-byte-ahead read fetch in both modes.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  // Frame phases of one select period
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_OPCODE,
    FS_ADDR,
    FS_READ,
    FS_WRITE,
    FS_SKIP
  } fs_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/spi_link_events.sv
module spi_link_events (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic sel,
  output logic start,
  output logic rise,
  output logic fall
);

  logic cs_p_q;
  logic sck_p_q;
  logic mode3_q;
  logic seen_rise_q;
  logic active;

  always_comb begin
    sel    = ~cs_n_s;
    start  = cs_p_q & ~cs_n_s;
    active = sel & hold_n_s & ~start;
    rise   = active & sck_s & ~sck_p_q;
    // in mode 3 the idle-high clock gives one leading fall that is not a shift point
    fall   = active & ~sck_s & sck_p_q & (~mode3_q | seen_rise_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p_q      <= 1'b1;
      sck_p_q     <= 1'b0;
      mode3_q     <= 1'b0;
      seen_rise_q <= 1'b0;
    end else begin
      cs_p_q  <= cs_n_s;
      sck_p_q <= sck_s;
      if (start) begin
        mode3_q     <= sck_s;
        seen_rise_q <= 1'b0;
      end else if (rise) begin
        seen_rise_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_sram_frame.sv
module spi_sram_frame
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ADDR_BYTES = 3,
  parameter logic [DATA_W-1:0] OP_READ = 8'h03,
  parameter logic [DATA_W-1:0] OP_WRITE = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              start,
  input  logic              rise,
  input  logic              fall,
  input  logic              hold_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int BC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(ADDR_BYTES - 1);

  fs_state_t         state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BC_W-1:0]   byte_q;
  logic              is_rd_q;
  logic [DATA_W-2:0] sh_q;
  logic [ADDR_W-1:0] acc_q;
  logic [ADDR_W-1:0] next_q;
  logic [DATA_W-1:0] rbuf_q;
  logic [DATA_W-2:0] osr_q;
  logic              miso_q;
  logic              oe_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0] mwd_q;
  logic              we_q;
  logic              re_q;
  logic              re_d_q;

  logic [DATA_W-1:0] byte_in;
  logic [ADDR_W-1:0] addr_in;

  always_comb begin
    byte_in = {sh_q, mosi};
    addr_in = ADDR_W'({acc_q, byte_in});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      is_rd_q <= 1'b0;
      sh_q    <= '0;
      acc_q   <= '0;
      next_q  <= '0;
      rbuf_q  <= '0;
      osr_q   <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
      maddr_q <= '0;
      mwd_q   <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      re_d_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      re_d_q <= re_q;
      if (re_d_q) rbuf_q <= mem_rdata;
      oe_q <= sel & hold_n & (state_q == FS_READ);

      if (!sel) begin
        state_q <= FS_IDLE;
      end else if (start) begin
        state_q <= FS_OPCODE;
        bit_q   <= '0;
        byte_q  <= '0;
      end else if (rise && state_q != FS_IDLE) begin
        sh_q  <= byte_in[DATA_W-2:0];
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          case (state_q)
            FS_OPCODE: begin
              if (byte_in == OP_READ) begin
                is_rd_q <= 1'b1;
                state_q <= FS_ADDR;
              end else if (byte_in == OP_WRITE) begin
                is_rd_q <= 1'b0;
                state_q <= FS_ADDR;
              end else begin
                state_q <= FS_SKIP;
              end
            end
            FS_ADDR: begin
              acc_q  <= addr_in;
              byte_q <= byte_q + 1'b1;
              if (byte_q == LAST_BYTE) begin
                if (is_rd_q) begin
                  re_q    <= 1'b1;
                  maddr_q <= addr_in;
                  next_q  <= addr_in + 1'b1;
                  miso_q  <= 1'b0;
                  state_q <= FS_READ;
                end else begin
                  next_q  <= addr_in;
                  state_q <= FS_WRITE;
                end
              end
            end
            FS_READ: begin
              re_q    <= 1'b1;
              maddr_q <= next_q;
              next_q  <= next_q + 1'b1;
            end
            FS_WRITE: begin
              we_q    <= 1'b1;
              maddr_q <= next_q;
              mwd_q   <= byte_in;
              next_q  <= next_q + 1'b1;
            end
            default: ;
          endcase
        end
      end else if (fall && state_q == FS_READ) begin
        if (bit_q == '0) begin
          miso_q <= rbuf_q[DATA_W-1];
          osr_q  <= rbuf_q[DATA_W-2:0];
        end else begin
          miso_q <= osr_q[DATA_W-2];
          osr_q  <= {osr_q[DATA_W-3:0], 1'b0};
        end
      end
    end
  end

  assign miso      = miso_q;
  assign miso_oe   = oe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwd_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;

endmodule

// File: rtl/spi_sram_front.sv
module spi_sram_front #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int ADDR_BYTES = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OP_READ = 8'h03,
  parameter logic [DATA_W-1:0] OP_WRITE = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_hold_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int PIN_N = 4;
  // order: hold_n, cs_n, sck, mosi; idle levels high for hold_n and cs_n
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1100;

  logic [PIN_N-1:0] pins_s;
  logic hold_n_s, cs_n_s, sck_s, mosi_s;
  logic sel_s, start_s, rise_s, fall_s;

  spi_pin_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_hold_n, spi_cs_n, spi_sck, spi_mosi}),
    .dout(pins_s)
  );

  assign {hold_n_s, cs_n_s, sck_s, mosi_s} = pins_s;

  spi_link_events u_events (
    .clk     (clk),
    .rst     (rst),
    .cs_n_s  (cs_n_s),
    .sck_s   (sck_s),
    .hold_n_s(hold_n_s),
    .sel     (sel_s),
    .start   (start_s),
    .rise    (rise_s),
    .fall    (fall_s)
  );

  spi_sram_frame #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ADDR_BYTES(ADDR_BYTES),
    .OP_READ   (OP_READ),
    .OP_WRITE  (OP_WRITE)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel_s),
    .start    (start_s),
    .rise     (rise_s),
    .fall     (fall_s),
    .hold_n   (hold_n_s),
    .mosi     (mosi_s),
    .mem_rdata(mem_rdata),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_re   (mem_re)
  );

endmodule

// File: rtl/spi_sram_front_chk.sv
module spi_sram_front_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              hold_n,
  input logic              start,
  input logic              miso_oe,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr
);

  logic              have_prev_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev_q <= 1'b0;
      prev_q      <= '0;
    end else if (start) begin
      have_prev_q <= 1'b0;
    end else if (mem_we || mem_re) begin
      have_prev_q <= 1'b1;
      prev_q      <= mem_addr;
    end
  end

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (rst) !sel |=> !miso_oe); // R7
  AST_OE_PAUSED: assert property (@(posedge clk) disable iff (rst) (sel && !hold_n) |=> !miso_oe); // R8
  AST_ACCESS_SELECTED: assert property (@(posedge clk) disable iff (rst) (mem_we || mem_re) |-> $past(sel)); // R7
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re)); // R11
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R11
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst) ((mem_we || mem_re) && have_prev_q) |-> (mem_addr == ADDR_W'(prev_q + 1'b1))); // R4 R5

endmodule

bind spi_sram_front spi_sram_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel     (sel_s),
  .hold_n  (hold_n_s),
  .start   (start_s),
  .miso_oe (spi_miso_oe),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .mem_addr(mem_addr)
);

// File: tb/spi_sram_front_bench.sv
`timescale 1ns/1ps
module spi_sram_front_bench;

  localparam int HP = 80;  // serial half period, ten system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, mem_we, mem_re;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_sram_front u_spi_sram_front (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // memory model indexed by the low address byte, one-cycle read latency
  logic [7:0] mem_model [256];
  logic [16:0] wa [64];
  logic [7:0] wd [64];
  int wcnt = 0, rcnt = 0, pulse_bad = 0;
  logic we_prev = 1'b0;
  bit oe_hi_seen = 1'b0;
  bit oe_low_seen = 1'b0;

  always @(posedge clk) begin
    if (mem_we) begin
      mem_model[mem_addr[7:0]] <= mem_wdata;
      wa[wcnt % 64] <= mem_addr;
      wd[wcnt % 64] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem_model[mem_addr[7:0]];
      rcnt <= rcnt + 1;
    end
    if ((mem_we && we_prev) || (mem_we && mem_re)) pulse_bad <= pulse_bad + 1;
    we_prev <= mem_we;
    if (miso_oe) oe_hi_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_begin(input bit m3);
    sck = m3;
    #HP;
    cs_n = 1'b0;
    #HP;
  endtask

  task automatic frame_end(input bit m3);
    if (!m3) sck = 1'b0;
    #HP;
    cs_n = 1'b1;
    #(4*HP);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_bit, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sck = 1'b0;
      mosi = tx[i];
      #HP;
      if (i == hold_bit) begin
        hold_n = 1'b0;
        #HP;
        chk(miso_oe == 1'b0, "R8 output released while paused", miso_oe, 0);
        sck = 1'b1; #HP; sck = 1'b0; #HP;
        hold_n = 1'b1;
        #HP;
      end
      rx[i] = miso;
      if (!miso_oe) oe_low_seen = 1'b1;
      sck = 1'b1;
      #HP;
    end
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    xfer(op, 8, -1, d);
    xfer(a[23:16], 8, -1, d);
    xfer(a[15:8], 8, -1, d);
    xfer(a[7:0], 8, -1, d);
  endtask

  // {mode3, address, data}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 24'h000005, 8'hA5},
    {1'b1, 24'h01ABCD, 8'h3C},
    {1'b0, 24'hFE0010, 8'h81},
    {1'b1, 24'h1FFFFF, 8'h7E},
    {1'b0, 24'h000080, 8'h00},
    {1'b1, 24'h00FF01, 8'hFF}
  };

  localparam logic [7:0] BURST [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  localparam logic [16:0] BURST_ADDR [4] = '{17'h1FFFE, 17'h1FFFF, 17'h00000, 17'h00001};

  initial begin
    logic [7:0] rx;
    int w0, r0;
    #3;
    #(10*8);
    chk(miso_oe == 1'b0, "R1 oe in reset", miso_oe, 0);
    chk(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
    chk(mem_re == 1'b0, "R1 re in reset", mem_re, 0);
    rst = 1'b0;
    #(10*8);
    chk(miso_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 idle after reset",
        {miso_oe, mem_we, mem_re}, 0);

    // table: write in one mode, read back in the other
    for (int i = 0; i < 6; i++) begin
      w0 = wcnt;
      frame_begin(VEC[i][32]);
      send_hdr(8'h02, VEC[i][31:8]);
      xfer(VEC[i][7:0], 8, -1, rx);
      frame_end(VEC[i][32]);
      chk(wcnt == w0 + 1, "R2 single write", wcnt - w0, 1);
      chk(wa[w0 % 64] == VEC[i][24:8], "R2 write address low 17 bits", wa[w0 % 64], VEC[i][24:8]);
      chk(wd[w0 % 64] == VEC[i][7:0], "R2 write data", wd[w0 % 64], VEC[i][7:0]);
      oe_low_seen = 1'b0;
      frame_begin(~VEC[i][32]);
      send_hdr(8'h03, VEC[i][31:8]);
      oe_low_seen = 1'b0;
      xfer(8'h00, 8, -1, rx);
      chk(oe_low_seen == 1'b0, "R3 oe during read data", oe_low_seen, 0);
      frame_end(~VEC[i][32]);
      chk(rx == VEC[i][7:0], "R3 R6 read back across modes", rx, VEC[i][7:0]);
    end

    // R4 R5: burst write across the wrap
    w0 = wcnt;
    frame_begin(1'b0);
    send_hdr(8'h02, 24'h01FFFE);
    for (int k = 0; k < 4; k++) xfer(BURST[k], 8, -1, rx);
    frame_end(1'b0);
    chk(wcnt == w0 + 4, "R4 burst write count", wcnt - w0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wa[(w0 + k) % 64] == BURST_ADDR[k], "R4 R5 burst write address", wa[(w0 + k) % 64], BURST_ADDR[k]);
      chk(wd[(w0 + k) % 64] == BURST[k], "R4 burst write data", wd[(w0 + k) % 64], BURST[k]);
    end

    // R4 R5 R8: burst read across the wrap, paused mid-byte
    frame_begin(1'b1);
    send_hdr(8'h03, 24'h01FFFE);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, 8, (k == 2) ? 4 : -1, rx);
      chk(rx == BURST[k], "R4 R5 R8 burst read data", rx, BURST[k]);
    end
    frame_end(1'b1);

    // R8: pause during a write burst
    w0 = wcnt;
    frame_begin(1'b0);
    send_hdr(8'h02, 24'h000020);
    xfer(8'hC3, 8, -1, rx);
    xfer(8'h5D, 8, 5, rx);
    frame_end(1'b0);
    chk(wcnt == w0 + 2, "R8 paused write count", wcnt - w0, 2);
    chk(wd[(w0 + 1) % 64] == 8'h5D, "R8 paused write data", wd[(w0 + 1) % 64], 8'h5D);
    chk(wa[(w0 + 1) % 64] == 17'h00021, "R8 paused write address", wa[(w0 + 1) % 64], 17'h00021);

    // R9: unknown command, later bytes look like commands
    w0 = wcnt; r0 = rcnt;
    #HP;
    oe_hi_seen = 1'b0;
    frame_begin(1'b0);
    xfer(8'hA5, 8, -1, rx);
    send_hdr(8'h02, 24'h000030);
    xfer(8'h03, 8, -1, rx);
    frame_end(1'b0);
    chk(wcnt == w0, "R9 no write after unknown command", wcnt - w0, 0);
    chk(rcnt == r0, "R9 no read after unknown command", rcnt - r0, 0);
    chk(oe_hi_seen == 1'b0, "R9 output stays released", oe_hi_seen, 0);

    // R7: activity while deselected
    w0 = wcnt; r0 = rcnt;
    #HP;
    oe_hi_seen = 1'b0;
    cs_n = 1'b1;
    for (int k = 0; k < 32; k++) begin
      sck = ~sck;
      mosi = k[1];
      #HP;
    end
    sck = 1'b0;
    #(4*HP);
    chk(wcnt == w0 && rcnt == r0, "R7 no access while deselected", (wcnt - w0) + (rcnt - r0), 0);
    chk(oe_hi_seen == 1'b0, "R7 output released while deselected", oe_hi_seen, 0);

    // R10: partial trailing byte dropped
    w0 = wcnt;
    frame_begin(1'b0);
    send_hdr(8'h02, 24'h000040);
    xfer(8'h99, 8, -1, rx);
    xfer(8'hF0, 5, -1, rx);
    frame_end(1'b0);
    chk(wcnt == w0 + 1, "R10 partial byte dropped", wcnt - w0, 1);
    chk(wd[w0 % 64] == 8'h99 && wa[w0 % 64] == 17'h00040, "R10 full byte kept", wd[w0 % 64], 8'h99);

    chk(pulse_bad == 0, "R11 strobe pulses", pulse_bad, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000*8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule